// File: doc/BRIEF.md
# Three-Counter Performance Monitor

This unit counts hardware events on three independent counters so that software can sample where a processor spends its time. Each counter watches one event line picked by a selection register. A counter advances only while the unit is globally running and the processor's current privilege level is not masked off. Counters 0 and 1 are 16 bits wide and counter 2 is 14 bits wide. Each counter can be set to flag an interrupt every 256 events or only when its whole width rolls over.

Software drives the unit through a single-cycle register port. Two addresses act as stop and go commands. Three addresses hold configuration: event selection, privilege masking and interrupt period. One address holds all three counts packed into a single 64-bit word. To preset a single counter, software reads that word, replaces one field and writes the whole word back. A further address exposes the sticky interrupt-pending bits, and each bit is cleared by writing a 1 to it.

Top module: `perf_count_unit`

## Requirements
- R1: After reset every counter reads 0, no interrupt is pending, and counting is stopped, so events have no effect until the go command is written.
- R2: The event for each counter comes from the selection register (address 2). Bit 31 picks `evt0[0]` or `evt0[1]` for counter 0. Bits 7:4 index `evt1` for counter 1. Bits 3:0 index `evt2` for counter 2. Pulses on lines that are not selected have no effect.
- R3: A counter adds exactly one per clock in which its selected event is high, the unit is running and the current privilege level is not masked.
- R4: The mask register (address 3) blocks counting at one privilege level per bit: bit 30 for user (`curMode` = 0), bit 8 for kernel (`curMode` = 1) and bit 9 for firmware (`curMode` = 2 or 3).
- R5: Writing address 0 stops all counting and writing address 1 resumes it. Count values are held while the unit is stopped.
- R6: Reading address 5 returns counter 0 in bits 63:48, counter 1 in bits 47:32 and counter 2 in bits 29:16. All other bits read as 0.
- R7: Writing address 5 loads all three counters at once from the same bit fields. Bit 0 and the other bits outside the fields are ignored. A load in the same cycle as an event takes precedence, and that cycle raises no interrupt.
- R8: Counters 0 and 1 wrap from 0xFFFF to 0, and counter 2 wraps from 0x3FFF to 0.
- R9: The period register (address 4) holds a 2-bit code per counter: bits 9:8 for counter 0, 7:6 for counter 1 and 5:4 for counter 2. With code 3, a counter sets its pending bit whenever its low 8 bits roll from 0xFF to 0x00.
- R10: With code 2, a counter sets its pending bit only when its full width wraps. With codes 0 and 1, a counter never sets its pending bit.
- R11: Pending bits are sticky and read back in bits 2:0 of address 6. Writing 1 to a bit clears it. An overflow in the same cycle as a clear leaves the bit set. `irq[i]` follows pending bit i, and `irqAny` is their OR.
- R12: Addresses 2, 3 and 4 read back only their defined bits, with 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data for `regAddr` (combinational) |
| curMode | input | 2 | Current privilege: 0 user, 1 kernel, 2/3 firmware |
| evt0 | input | 2 | Event candidates for counter 0 |
| evt1 | input | 16 | Event candidates for counter 1 |
| evt2 | input | 16 | Event candidates for counter 2 |
| irq | output | 3 | Per-counter interrupt pending |
| irqAny | output | 1 | OR of the pending bits |

## Verification
Selected and unselected event lines are pulsed with the same lengths, so a selection decode error shows up as a count difference. The privilege mask is tried at every `curMode` value with different mask bits set, which separates the user, kernel and firmware gates from one another. Preloads place counters just below the 8-bit and full-width boundaries under each period code, which tells 256-event overflow apart from full wrap and from no interrupt, and shows that the 14-bit counter wraps sooner. Single cycles that combine a load with an event, or a clear with an overflow, check which of the two takes precedence.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int unsigned DATA_W = 64;
  localparam int unsigned NUM_CNT = 3;

  // Register addresses
  localparam logic [2:0] ADR_STOP = 3'd0;
  localparam logic [2:0] ADR_GO   = 3'd1;
  localparam logic [2:0] ADR_SEL  = 3'd2;
  localparam logic [2:0] ADR_MASK = 3'd3;
  localparam logic [2:0] ADR_PER  = 3'd4;
  localparam logic [2:0] ADR_CNT  = 3'd5;
  localparam logic [2:0] ADR_PEND = 3'd6;

  // Field positions software relies on
  localparam int unsigned SEL0_BIT   = 31;
  localparam int unsigned SEL1_LSB   = 4;
  localparam int unsigned SEL2_LSB   = 0;
  localparam int unsigned MASK_U_BIT = 30;
  localparam int unsigned MASK_K_BIT = 8;
  localparam int unsigned MASK_F_BIT = 9;
  localparam int unsigned PER0_LSB   = 8;
  localparam int unsigned PER1_LSB   = 6;
  localparam int unsigned PER2_LSB   = 4;
  localparam int unsigned CNT0_LSB   = 48;
  localparam int unsigned CNT1_LSB   = 32;
  localparam int unsigned CNT2_LSB   = 16;

  // Period codes
  localparam logic [1:0] PER_FULL  = 2'd2;
  localparam logic [1:0] PER_SHORT = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntLoad;
    logic pendClr;
  } pcuStrobes_t;

  // Flat count layout: counter 2 lowest, then counter 1, then counter 0
  function automatic int cntWid(input int idx, input int w01, input int w2);
    return (idx == 2) ? w2 : w01;
  endfunction

  function automatic int cntOff(input int idx, input int w01, input int w2);
    return (idx == 2) ? 0 : (idx == 1) ? w2 : (w2 + w01);
  endfunction

endpackage

// File: rtl/pcu_counter.sv
module pcu_counter
  import pcu_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned PRE_W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic [1:0]   perCode,
  output logic [W-1:0] cnt,
  output logic         ovf
);

  logic preWrap;
  logic fullWrap;

  assign preWrap  = &cnt[PRE_W-1:0];
  assign fullWrap = &cnt;

  always_comb begin
    ovf = 1'b0;
    if (inc && !load) begin
      if (perCode == PER_SHORT) ovf = preWrap;
      else if (perCode == PER_FULL) ovf = fullWrap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (load) cnt <= loadVal;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inc && !load) |=> $stable(cnt));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !load) |=> (cnt == $past(cnt) + 1'b1));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (cnt == $past(loadVal)));

endmodule

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
#(
  parameter int unsigned W01 = 16,
  parameter int unsigned W2  = 14,
  localparam int unsigned TOT = 2 * W01 + W2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [1:0]        curMode,
  input  logic [TOT-1:0]    cntFlat,
  input  logic [2:0]        pend,
  output pcuStrobes_t       strb,
  output logic              countOk,
  output logic [TOT-1:0]    loadFlat,
  output logic [2:0]        clrBits,
  output logic              sel0,
  output logic [3:0]        sel1,
  output logic [3:0]        sel2,
  output logic [2:0][1:0]   perCode,
  output logic [DATA_W-1:0] regRdata
);

  logic runEn;
  logic maskU, maskK, maskF;
  logic suppressed;
  logic stopCmd, goCmd, selWr, maskWr, perWr;
  logic unusedWdata;

  assign unusedWdata = ^regWdata[15:10];

  always_comb begin
    strb    = '0;
    stopCmd = 1'b0;
    goCmd   = 1'b0;
    selWr   = 1'b0;
    maskWr  = 1'b0;
    perWr   = 1'b0;
    if (regWe) begin
      case (regAddr)
        ADR_STOP: stopCmd      = 1'b1;
        ADR_GO:   goCmd        = 1'b1;
        ADR_SEL:  selWr        = 1'b1;
        ADR_MASK: maskWr       = 1'b1;
        ADR_PER:  perWr        = 1'b1;
        ADR_CNT:  strb.cntLoad = 1'b1;
        ADR_PEND: strb.pendClr = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn   <= 1'b0;
      sel0    <= 1'b0;
      sel1    <= '0;
      sel2    <= '0;
      maskU   <= 1'b0;
      maskK   <= 1'b0;
      maskF   <= 1'b0;
      perCode <= '0;
    end else begin
      if (stopCmd) runEn <= 1'b0;
      if (goCmd)   runEn <= 1'b1;
      if (selWr) begin
        sel0 <= regWdata[SEL0_BIT];
        sel1 <= regWdata[SEL1_LSB +: 4];
        sel2 <= regWdata[SEL2_LSB +: 4];
      end
      if (maskWr) begin
        maskU <= regWdata[MASK_U_BIT];
        maskK <= regWdata[MASK_K_BIT];
        maskF <= regWdata[MASK_F_BIT];
      end
      if (perWr) begin
        perCode[0] <= regWdata[PER0_LSB +: 2];
        perCode[1] <= regWdata[PER1_LSB +: 2];
        perCode[2] <= regWdata[PER2_LSB +: 2];
      end
    end
  end

  always_comb begin
    case (curMode)
      2'b00:   suppressed = maskU;
      2'b01:   suppressed = maskK;
      default: suppressed = maskF;
    endcase
  end

  assign countOk = runEn & ~suppressed;

  assign loadFlat = {regWdata[CNT0_LSB +: W01],
                     regWdata[CNT1_LSB +: W01],
                     regWdata[CNT2_LSB +: W2]};
  assign clrBits  = regWdata[2:0];

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADR_SEL: begin
        regRdata[SEL0_BIT]        = sel0;
        regRdata[SEL1_LSB +: 4]   = sel1;
        regRdata[SEL2_LSB +: 4]   = sel2;
      end
      ADR_MASK: begin
        regRdata[MASK_U_BIT] = maskU;
        regRdata[MASK_K_BIT] = maskK;
        regRdata[MASK_F_BIT] = maskF;
      end
      ADR_PER: begin
        regRdata[PER0_LSB +: 2] = perCode[0];
        regRdata[PER1_LSB +: 2] = perCode[1];
        regRdata[PER2_LSB +: 2] = perCode[2];
      end
      ADR_CNT: begin
        regRdata[CNT0_LSB +: W01] = cntFlat[W2 + W01 +: W01];
        regRdata[CNT1_LSB +: W01] = cntFlat[W2 +: W01];
        regRdata[CNT2_LSB +: W2]  = cntFlat[0 +: W2];
      end
      ADR_PEND: regRdata[2:0] = pend;
      default: ;
    endcase
  end

  // R5
  stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADR_STOP) |=> !countOk);

endmodule

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
#(
  parameter int unsigned W01   = 16,
  parameter int unsigned W2    = 14,
  parameter int unsigned PRE_W = 8,
  localparam int unsigned TOT  = 2 * W01 + W2
) (
  input  logic            clk,
  input  logic            rstN,
  input  pcuStrobes_t     strb,
  input  logic            countOk,
  input  logic [TOT-1:0]  loadFlat,
  input  logic [2:0]      clrBits,
  input  logic            sel0,
  input  logic [3:0]      sel1,
  input  logic [3:0]      sel2,
  input  logic [2:0][1:0] perCode,
  input  logic [1:0]      evt0,
  input  logic [15:0]     evt1,
  input  logic [15:0]     evt2,
  output logic [TOT-1:0]  cntFlat,
  output logic [2:0]      pend
);

  logic [2:0] hit;
  logic [2:0] ovf;
  logic [2:0] clrMask;

  always_comb begin
    hit[0] = evt0[sel0];
    hit[1] = evt1[sel1];
    hit[2] = evt2[sel2];
  end

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    localparam int CW  = cntWid(gi, W01, W2);
    localparam int OFF = cntOff(gi, W01, W2);

    pcu_counter #(.W(CW), .PRE_W(PRE_W)) u_cnt (
      .clk     (clk),
      .rstN    (rstN),
      .inc     (countOk & hit[gi]),
      .load    (strb.cntLoad),
      .loadVal (loadFlat[OFF +: CW]),
      .perCode (perCode[gi]),
      .cnt     (cntFlat[OFF +: CW]),
      .ovf     (ovf[gi])
    );
  end

  assign clrMask = strb.pendClr ? clrBits : 3'b000;

  always_ff @(posedge clk) begin
    if (!rstN) pend <= '0;
    else pend <= (pend & ~clrMask) | ovf;
  end

  // R5
  gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!countOk && !strb.cntLoad) |=> $stable(cntFlat));

  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pend & $past(pend & ~clrMask)) == $past(pend & ~clrMask)));

endmodule

// File: rtl/perf_count_unit.sv
module perf_count_unit
  import pcu_pkg::*;
#(
  parameter int unsigned W01   = 16,
  parameter int unsigned W2    = 14,
  parameter int unsigned PRE_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [63:0] regWdata,
  output logic [63:0] regRdata,
  input  logic [1:0]  curMode,
  input  logic [1:0]  evt0,
  input  logic [15:0] evt1,
  input  logic [15:0] evt2,
  output logic [2:0]  irq,
  output logic        irqAny
);

  localparam int unsigned TOT = 2 * W01 + W2;

  pcuStrobes_t     strb;
  logic            countOk;
  logic [TOT-1:0]  loadFlat;
  logic [TOT-1:0]  cntFlat;
  logic [2:0]      clrBits;
  logic [2:0]      pend;
  logic            sel0;
  logic [3:0]      sel1;
  logic [3:0]      sel2;
  logic [2:0][1:0] perCode;

  pcu_ctrl #(.W01(W01), .W2(W2)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .curMode  (curMode),
    .cntFlat  (cntFlat),
    .pend     (pend),
    .strb     (strb),
    .countOk  (countOk),
    .loadFlat (loadFlat),
    .clrBits  (clrBits),
    .sel0     (sel0),
    .sel1     (sel1),
    .sel2     (sel2),
    .perCode  (perCode),
    .regRdata (regRdata)
  );

  pcu_datapath #(.W01(W01), .W2(W2), .PRE_W(PRE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .countOk  (countOk),
    .loadFlat (loadFlat),
    .clrBits  (clrBits),
    .sel0     (sel0),
    .sel1     (sel1),
    .sel2     (sel2),
    .perCode  (perCode),
    .evt0     (evt0),
    .evt1     (evt1),
    .evt2     (evt2),
    .cntFlat  (cntFlat),
    .pend     (pend)
  );

  assign irq    = pend;
  assign irqAny = |pend;

endmodule

// File: tb/perf_count_unit_test.sv
`timescale 1ns/1ps
module perf_count_unit_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [2:0]  regAddr;
  logic [63:0] regWdata;
  logic [63:0] regRdata;
  logic [1:0]  curMode;
  logic [1:0]  evt0;
  logic [15:0] evt1;
  logic [15:0] evt2;
  logic [2:0]  irq;
  logic        irqAny;

  int nChk = 0;
  int nErr = 0;
  bit rdActive = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } sbItem_t;
  sbItem_t sbQ[$];

  always #2.5 clk = ~clk;

  perf_count_unit uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .curMode(curMode),
    .evt0(evt0), .evt1(evt1), .evt2(evt2), .irq(irq), .irqAny(irqAny)
  );

  function automatic logic [63:0] cw(input logic [15:0] c0, input logic [15:0] c1,
                                     input logic [13:0] c2);
    return {c0, c1, 2'b00, c2, 16'h0000};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data and compares
  always @(posedge clk) begin
    #1;
    if (rdActive) begin
      if (sbQ.size() == 0) check(1'b0, "scoreboard empty", regRdata, 64'h0);
      else begin
        sbItem_t it;
        it = sbQ.pop_front();
        check(regRdata === it.exp, it.tag, regRdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rdExp(input logic [2:0] a, input logic [63:0] e, input string tag);
    sbItem_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    regAddr = a; rdActive = 1'b1;
    @(negedge clk);
    rdActive = 1'b0;
  endtask

  task automatic pulse(input logic [1:0] e0, input logic [15:0] e1,
                       input logic [15:0] e2, input int n);
    @(negedge clk);
    evt0 = e0; evt1 = e1; evt2 = e2;
    repeat (n) @(negedge clk);
    evt0 = '0; evt1 = '0; evt2 = '0;
  endtask

  // events plus a register write in the same single cycle
  task automatic evtAndWr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    evt0 = 2'b10; evt1 = 16'h0008; evt2 = 16'h0020;
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    evt0 = '0; evt1 = '0; evt2 = '0; regWe = 1'b0; regWdata = '0;
  endtask

  task automatic chkIrq(input logic [2:0] e, input string tag);
    @(negedge clk);
    check(irq === e && irqAny === (|e), tag, {60'h0, irqAny, irq}, {60'h0, |e, e});
  endtask

  localparam logic [1:0]  S0 = 2'b10;     // selected lines
  localparam logic [15:0] S1 = 16'h0008;
  localparam logic [15:0] S2 = 16'h0020;

  initial begin
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    curMode = 2'd0; evt0 = '0; evt1 = '0; evt2 = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdExp(3'd5, 64'h0, "R1 counts after reset");
    rdExp(3'd6, 64'h0, "R1 pending after reset");
    chkIrq(3'b000, "R1 irq after reset");

    // R12 selection readback, garbage bits dropped
    wr(3'd2, 64'hFFFF_0000_8000_0035);
    rdExp(3'd2, 64'h0000_0000_8000_0035, "R12 select readback");

    // R1 stopped: events ignored
    pulse(S0, S1, S2, 10);
    rdExp(3'd5, 64'h0, "R1 no count before go");

    // R3 R6 counting after go
    wr(3'd1, 64'h0);
    pulse(S0, S1, S2, 10);
    rdExp(3'd5, cw(16'd10, 16'd10, 14'd10), "R3 R6 ten events counted");

    // R2 unselected lines
    pulse(2'b01, 16'hFFF7, 16'hFFDF, 5);
    rdExp(3'd5, cw(16'd10, 16'd10, 14'd10), "R2 unselected events ignored");

    // R4 privilege masking
    wr(3'd3, 64'h100);
    curMode = 2'd1;
    pulse(S0, S1, S2, 4);
    rdExp(3'd5, cw(16'd10, 16'd10, 14'd10), "R4 kernel masked");
    curMode = 2'd0;
    pulse(S0, S1, S2, 3);
    rdExp(3'd5, cw(16'd13, 16'd13, 14'd13), "R4 user counts with kernel mask");
    wr(3'd3, 64'hFFFF_0000_4000_0200);
    rdExp(3'd3, 64'h0000_0000_4000_0200, "R12 mask readback");
    pulse(S0, S1, S2, 2);
    curMode = 2'd2;
    pulse(S0, S1, S2, 2);
    curMode = 2'd3;
    pulse(S0, S1, S2, 2);
    rdExp(3'd5, cw(16'd13, 16'd13, 14'd13), "R4 user and firmware masked");
    curMode = 2'd1;
    pulse(S0, S1, S2, 2);
    rdExp(3'd5, cw(16'd15, 16'd15, 14'd15), "R4 kernel counts");
    wr(3'd3, 64'h0);
    curMode = 2'd0;

    // R5 stop / go
    wr(3'd0, 64'h0);
    pulse(S0, S1, S2, 5);
    rdExp(3'd5, cw(16'd15, 16'd15, 14'd15), "R5 held while stopped");
    wr(3'd1, 64'h0);
    pulse(S0, S1, S2, 1);
    rdExp(3'd5, cw(16'd16, 16'd16, 14'd16), "R5 resumes after go");

    // R9 R10 period codes: c0 full, c1 short, c2 none
    wr(3'd4, 64'hFFFF_0000_0000_02C0);
    rdExp(3'd4, 64'h2C0, "R12 period readback");
    wr(3'd5, {16'hFFFE, 16'h00FE, 2'b11, 14'h3FFE, 16'h1235});
    rdExp(3'd5, cw(16'hFFFE, 16'h00FE, 14'h3FFE), "R7 load ignores stray bits");
    pulse(S0, S1, S2, 1);
    chkIrq(3'b000, "R9 no interrupt before boundary");
    pulse(S0, S1, S2, 1);
    rdExp(3'd5, cw(16'h0000, 16'h0100, 14'h0000), "R8 wrap widths");
    chkIrq(3'b011, "R9 R10 short and full overflow, code 0 silent");
    rdExp(3'd6, 64'h3, "R11 pending readback");

    // R11 clear
    wr(3'd6, 64'h1);
    chkIrq(3'b010, "R11 write-one clears bit 0");
    pulse(S0, S1, S2, 2);
    chkIrq(3'b010, "R11 bit 1 stays pending");
    wr(3'd6, 64'h6);
    chkIrq(3'b000, "R11 all cleared");

    // R7 load beats event
    evtAndWr(3'd5, cw(16'd5, 16'd6, 14'd7));
    rdExp(3'd5, cw(16'd5, 16'd6, 14'd7), "R7 load wins over event");

    // R9 R10 codes c0 short, c1 full, c2 short
    wr(3'd4, 64'h3B0);
    wr(3'd5, cw(16'h00FF, 16'h00FF, 14'h00FF));
    pulse(S0, S1, S2, 1);
    chkIrq(3'b101, "R10 byte roll under full code is silent");

    // R11 overflow in the clear cycle keeps the bit
    wr(3'd5, cw(16'h02FF, 16'h0, 14'h0));
    evtAndWr(3'd6, 64'h1);
    chkIrq(3'b101, "R11 set wins over clear");
    rdExp(3'd5, cw(16'h0300, 16'h0001, 14'h0001), "R3 counts in clear cycle");
    wr(3'd6, 64'h7);
    chkIrq(3'b000, "R11 final clear");

    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

endmodule